// File: doc/BRIEF.md
# Constant-Folding Register Renamer

This block renames a stream of two-source, one-destination micro-ops, up to two per cycle, in program order. For every logical register it holds the physical register that currently names it and a short symbolic note on how that value was made: either "some base physical register combined with a constant under one operator", or "unknown". A destination is given the next tag from an external free list.

While renaming, the block looks at the note attached to the first source. If the incoming op is an add-immediate, an OR-immediate or a logical right shift by an immediate, and the source was itself made by the same kind of operation, the op is rewritten to read the older base register with a merged constant. A chain of dependent increments therefore leaves the stage as one-deep operations on a common base, and a later consumer never waits for the intermediate result. Saturating adds, loads, register-register ops, left shifts and any pairing of different operators are renamed plainly and leave an "unknown" note. A flush returns the map to its power-up state.

Top module: `rnf_renamer`

## Requirements
- R1: After reset and after any cycle with `flush` high, logical register i maps to physical register i with an "unknown" note, and `out_valid` is 0 in the cycle that follows the flush.
- R2: Opcode encoding on `in_op`: 0 no-op, 1 add-immediate, 2 OR-immediate, 3 logical right shift by immediate, 4 left shift by immediate, 5 saturating add-immediate, 6 register-register ALU op, 7 load. Every accepted op other than opcode 0 takes the next free tag in slot order (slot 0 first) as its destination, `free_pop` equals the number of such ops, and the logical destination maps to that tag from then on.
- R3: An add-immediate whose first source carries the note "base P plus K" is emitted with source P and immediate K + imm modulo 2^32, and `out_folded` set.
- R4: A folded op leaves for its destination the note built from its folded form, so a third increment in a row of +1 on the same base is emitted as base plus 3.
- R5: An OR-immediate whose first source carries the note "base P OR K" is emitted with source P and immediate K | imm.
- R6: A right shift whose first source carries "base P shifted right by K" is emitted with source P and count min(K + min(imm,32), 32); a count of 32 means an all-zero result. Shift counts in notes are held capped at 32.
- R7: A fold happens only when the incoming operator and the note's operator are the same one of add, OR and right shift. Otherwise the op is emitted with the mapped physical register of each source, its own immediate and `out_folded` clear; left shifts, saturating adds, register-register ops and loads leave an "unknown" note.
- R8: Within one group, slot 1 reads slot 0's new mapping and note when slot 1's source matches slot 0's destination.
- R9: `in_ready` is low while `flush` is high or `free_cnt` is less than the number of destination-writing valid ops; a group offered then is not taken, `free_pop` is 0 and the map is unchanged.
- R10: An accepted group appears on the outputs one cycle later with `out_valid` equal to the accepted `in_valid`; with nothing accepted `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore the map to its power-up state |
| in_valid | input | 2 | Per-slot valid of the offered group |
| in_op | input | 6 | Per-slot 3-bit opcode |
| in_dst | input | 10 | Per-slot 5-bit logical destination |
| in_src1 | input | 10 | Per-slot 5-bit first logical source |
| in_src2 | input | 10 | Per-slot 5-bit second logical source |
| in_imm | input | 64 | Per-slot 32-bit immediate |
| in_ready | output | 1 | Group is taken on this edge when high |
| free_cnt | input | 2 | Number of free tags available (0 to 2) |
| free_tag | input | 12 | Next two free 6-bit tags, slot-order first in the low bits |
| free_pop | output | 2 | Number of free tags consumed this cycle |
| out_valid | output | 2 | Per-slot valid of the renamed group |
| out_op | output | 6 | Per-slot opcode |
| out_pdst | output | 12 | Per-slot physical destination |
| out_psrc1 | output | 12 | Per-slot physical first source (base if folded) |
| out_psrc2 | output | 12 | Per-slot physical second source |
| out_imm | output | 64 | Per-slot immediate (merged if folded) |
| out_folded | output | 2 | Per-slot flag: op was rewritten |

## Verification
The hardest case to reach is a fold that crosses both slots of one group and then continues into the next group, because the second slot must see a note that exists only combinationally and the next group must see it stored. The stimulus builds dependent chains of every foldable operator, places producer and consumer in the same group and in consecutive groups, interleaves mismatched operators between them, and drives shift sums past the 32 cap and add sums past 2^32. A bench-side map model predicts every rewritten op, and stalls and flushes are followed by reads that expose whether the stored map moved.

// File: rtl/rnf_pkg.sv
`timescale 1ns/1ps
package rnf_pkg;
  localparam int NLOG    = 32;
  localparam int NPHYS   = 64;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 3;
  localparam int LREG_W  = $clog2(NLOG);
  localparam int PREG_W  = $clog2(NPHYS);
  localparam int SHIFT_CAP = DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_ORI    = 3'd2,
    OP_SRLI   = 3'd3,
    OP_SLLI   = 3'd4,
    OP_ADDSAT = 3'd5,
    OP_ALURR  = 3'd6,
    OP_LOAD   = 3'd7
  } uop_kind_e;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ADD  = 2'd1,
    SYM_OR   = 2'd2,
    SYM_SHR  = 2'd3
  } sym_e;

  typedef struct packed {
    logic [PREG_W-1:0] preg;
    sym_e              sym;
    logic [PREG_W-1:0] base;
    logic [DATA_W-1:0] k;
  } map_ent_t;

  function automatic sym_e sym_of(input uop_kind_e op);
    case (op)
      OP_ADDI: return SYM_ADD;
      OP_ORI:  return SYM_OR;
      OP_SRLI: return SYM_SHR;
      default: return SYM_NONE;
    endcase
  endfunction

  function automatic logic writes_dst(input uop_kind_e op);
    return op != OP_NOP;
  endfunction

  function automatic logic [DATA_W-1:0] cap_shift(input logic [DATA_W:0] x);
    if (x >= (DATA_W+1)'(SHIFT_CAP)) return DATA_W'(SHIFT_CAP);
    return x[DATA_W-1:0];
  endfunction

  function automatic map_ent_t home_ent(input int idx);
    map_ent_t e;
    e.preg = PREG_W'(idx);
    e.sym  = SYM_NONE;
    e.base = '0;
    e.k    = '0;
    return e;
  endfunction
endpackage

// File: rtl/rnf_tag_alloc.sv
`timescale 1ns/1ps
module rnf_tag_alloc
  import rnf_pkg::*;
#(
  parameter int GROUP = 2,
  localparam int CNT_W = $clog2(GROUP+1)
) (
  input  logic [GROUP-1:0]        valid,
  input  logic [GROUP*OP_W-1:0]   op,
  input  logic [GROUP*PREG_W-1:0] free_tag,
  output logic [GROUP-1:0]        slot_wr,
  output logic [GROUP*PREG_W-1:0] slot_tag,
  output logic [CNT_W-1:0]        need
);
  always_comb begin
    logic [CNT_W-1:0] cnt;
    cnt = '0;
    slot_wr = '0;
    slot_tag = '0;
    for (int k = 0; k < GROUP; k++) begin
      slot_wr[k] = valid[k] && writes_dst(uop_kind_e'(op[k*OP_W +: OP_W]));
      slot_tag[k*PREG_W +: PREG_W] = free_tag[32'(cnt)*PREG_W +: PREG_W];
      if (slot_wr[k]) cnt = cnt + 1'b1;
    end
    need = cnt;
  end
endmodule

// File: rtl/rnf_fold.sv
`timescale 1ns/1ps
module rnf_fold
  import rnf_pkg::*;
(
  input  uop_kind_e         op,
  input  logic [DATA_W-1:0] imm,
  input  map_ent_t          src1_ent,
  input  map_ent_t          src2_ent,
  input  logic [PREG_W-1:0] dst_tag,
  output logic [PREG_W-1:0] psrc1,
  output logic [PREG_W-1:0] psrc2,
  output logic [DATA_W-1:0] imm_out,
  output logic              folded,
  output map_ent_t          dst_ent
);
  sym_e              cls;
  logic [DATA_W-1:0] imm_cap;
  logic [DATA_W-1:0] fold_k;

  always_comb begin
    cls     = sym_of(op);
    folded  = (cls != SYM_NONE) && (src1_ent.sym == cls);
    imm_cap = cap_shift({1'b0, imm});
    case (cls)
      SYM_ADD: fold_k = src1_ent.k + imm;
      SYM_OR:  fold_k = src1_ent.k | imm;
      SYM_SHR: fold_k = cap_shift({1'b0, src1_ent.k} + {1'b0, imm_cap});
      default: fold_k = imm;
    endcase

    psrc1   = folded ? src1_ent.base : src1_ent.preg;
    psrc2   = src2_ent.preg;
    imm_out = folded ? fold_k : imm;

    dst_ent.preg = dst_tag;
    dst_ent.sym  = cls;
    if (cls == SYM_NONE) begin
      dst_ent.base = '0;
      dst_ent.k    = '0;
    end else begin
      dst_ent.base = psrc1;
      if (folded)              dst_ent.k = fold_k;
      else if (cls == SYM_SHR) dst_ent.k = imm_cap;
      else                     dst_ent.k = imm;
    end
  end
endmodule

// File: rtl/rnf_map_table.sv
`timescale 1ns/1ps
module rnf_map_table
  import rnf_pkg::*;
#(
  parameter int GROUP = 2,
  localparam int NRD = 2*GROUP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [GROUP-1:0]        we,
  input  logic [GROUP*LREG_W-1:0] widx,
  input  map_ent_t                went [GROUP],
  input  logic [NRD*LREG_W-1:0]   ridx,
  output map_ent_t                rent [NRD]
);
  map_ent_t tbl_q [NLOG];
  map_ent_t tbl_d [NLOG];

  always_comb begin
    for (int i = 0; i < NLOG; i++) tbl_d[i] = tbl_q[i];
    if (flush) begin
      for (int i = 0; i < NLOG; i++) tbl_d[i] = home_ent(i);
    end else begin
      for (int k = 0; k < GROUP; k++)
        if (we[k]) tbl_d[widx[k*LREG_W +: LREG_W]] = went[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) tbl_q[i] <= home_ent(i);
    end else begin
      for (int i = 0; i < NLOG; i++) tbl_q[i] <= tbl_d[i];
    end
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) rent[r] = tbl_q[ridx[r*LREG_W +: LREG_W]];
  end
endmodule

// File: rtl/rnf_renamer.sv
`timescale 1ns/1ps
module rnf_renamer
  import rnf_pkg::*;
#(
  parameter int GROUP = 2,
  localparam int CNT_W = $clog2(GROUP+1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [GROUP-1:0]        in_valid,
  input  logic [GROUP*OP_W-1:0]   in_op,
  input  logic [GROUP*LREG_W-1:0] in_dst,
  input  logic [GROUP*LREG_W-1:0] in_src1,
  input  logic [GROUP*LREG_W-1:0] in_src2,
  input  logic [GROUP*DATA_W-1:0] in_imm,
  output logic                    in_ready,
  input  logic [CNT_W-1:0]        free_cnt,
  input  logic [GROUP*PREG_W-1:0] free_tag,
  output logic [CNT_W-1:0]        free_pop,
  output logic [GROUP-1:0]        out_valid,
  output logic [GROUP*OP_W-1:0]   out_op,
  output logic [GROUP*PREG_W-1:0] out_pdst,
  output logic [GROUP*PREG_W-1:0] out_psrc1,
  output logic [GROUP*PREG_W-1:0] out_psrc2,
  output logic [GROUP*DATA_W-1:0] out_imm,
  output logic [GROUP-1:0]        out_folded
);
  localparam int NRD = 2*GROUP;

  logic [GROUP-1:0]        slot_wr;
  logic [GROUP*PREG_W-1:0] slot_tag;
  logic [CNT_W-1:0]        need;
  logic                    accept;
  logic [GROUP-1:0]        tbl_we;
  logic [NRD*LREG_W-1:0]   rd_idx;
  map_ent_t                rd_ent  [NRD];
  map_ent_t                new_ent [GROUP];
  map_ent_t                s1_ent  [GROUP];
  map_ent_t                s2_ent  [GROUP];
  logic [GROUP*PREG_W-1:0] ps1_d, ps2_d;
  logic [GROUP*DATA_W-1:0] imm_d;
  logic [GROUP-1:0]        fold_d;

  rnf_tag_alloc #(.GROUP(GROUP)) u_alloc (
    .valid    (in_valid),
    .op       (in_op),
    .free_tag (free_tag),
    .slot_wr  (slot_wr),
    .slot_tag (slot_tag),
    .need     (need)
  );

  // Group is taken only when every destination can be given a tag.
  always_comb begin
    in_ready = !flush && (free_cnt >= need);
    accept   = in_ready && (|in_valid);
    free_pop = accept ? need : '0;
    tbl_we   = accept ? slot_wr : '0;
  end

  always_comb begin
    for (int k = 0; k < GROUP; k++) begin
      rd_idx[(2*k)*LREG_W   +: LREG_W] = in_src1[k*LREG_W +: LREG_W];
      rd_idx[(2*k+1)*LREG_W +: LREG_W] = in_src2[k*LREG_W +: LREG_W];
    end
  end

  rnf_map_table #(.GROUP(GROUP)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .we    (tbl_we),
    .widx  (in_dst),
    .went  (new_ent),
    .ridx  (rd_idx),
    .rent  (rd_ent)
  );

  for (genvar k = 0; k < GROUP; k++) begin : g_slot
    // Older slots of the same group override the stored entry (youngest wins).
    always_comb begin
      s1_ent[k] = rd_ent[2*k];
      s2_ent[k] = rd_ent[2*k+1];
      for (int j = 0; j < k; j++) begin
        if (slot_wr[j] && in_dst[j*LREG_W +: LREG_W] == in_src1[k*LREG_W +: LREG_W])
          s1_ent[k] = new_ent[j];
        if (slot_wr[j] && in_dst[j*LREG_W +: LREG_W] == in_src2[k*LREG_W +: LREG_W])
          s2_ent[k] = new_ent[j];
      end
    end

    rnf_fold u_fold (
      .op       (uop_kind_e'(in_op[k*OP_W +: OP_W])),
      .imm      (in_imm[k*DATA_W +: DATA_W]),
      .src1_ent (s1_ent[k]),
      .src2_ent (s2_ent[k]),
      .dst_tag  (slot_tag[k*PREG_W +: PREG_W]),
      .psrc1    (ps1_d[k*PREG_W +: PREG_W]),
      .psrc2    (ps2_d[k*PREG_W +: PREG_W]),
      .imm_out  (imm_d[k*DATA_W +: DATA_W]),
      .folded   (fold_d[k]),
      .dst_ent  (new_ent[k])
    );
  end

  // Output stage: valid always clocked, payload clock-enabled by accept.
  logic [GROUP-1:0] out_valid_d;
  always_comb begin
    if (flush)       out_valid_d = '0;
    else if (accept) out_valid_d = in_valid;
    else             out_valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= '0;
    else        out_valid <= out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_op     <= '0;
      out_pdst   <= '0;
      out_psrc1  <= '0;
      out_psrc2  <= '0;
      out_imm    <= '0;
      out_folded <= '0;
    end else if (accept) begin
      out_op     <= in_op;
      out_pdst   <= slot_tag;
      out_psrc1  <= ps1_d;
      out_psrc2  <= ps2_d;
      out_imm    <= imm_d;
      out_folded <= fold_d & in_valid;
    end
  end
endmodule

// File: rtl/rnf_renamer_chk.sv
`timescale 1ns/1ps
module rnf_renamer_chk
  import rnf_pkg::*;
#(
  parameter int GROUP = 2,
  localparam int CNT_W = $clog2(GROUP+1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic [GROUP-1:0]        in_valid,
  input logic                    in_ready,
  input logic [CNT_W-1:0]        free_cnt,
  input logic [CNT_W-1:0]        free_pop,
  input logic [GROUP-1:0]        out_valid,
  input logic [GROUP*OP_W-1:0]   out_op,
  input logic [GROUP*DATA_W-1:0] out_imm,
  input logic [GROUP-1:0]        out_folded
);
  assert_stall_no_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> free_pop == '0);

  assert_pop_within_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    free_pop <= free_cnt);

  assert_out_follows_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid && in_ready) |=> out_valid == $past(in_valid));

  assert_idle_no_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|in_valid && in_ready) |=> out_valid == '0);

  assert_flush_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> out_valid == '0);

  for (genvar k = 0; k < GROUP; k++) begin : g_chk
    assert_shift_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && out_folded[k] && out_op[k*OP_W +: OP_W] == OP_SRLI)
        |-> out_imm[k*DATA_W +: DATA_W] <= DATA_W'(SHIFT_CAP));

    assert_fold_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[k] && out_folded[k]) |->
        (out_op[k*OP_W +: OP_W] == OP_ADDI || out_op[k*OP_W +: OP_W] == OP_ORI ||
         out_op[k*OP_W +: OP_W] == OP_SRLI));
  end
endmodule

bind rnf_renamer rnf_renamer_chk #(.GROUP(GROUP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .free_cnt   (free_cnt),
  .free_pop   (free_pop),
  .out_valid  (out_valid),
  .out_op     (out_op),
  .out_imm    (out_imm),
  .out_folded (out_folded)
);

// File: tb/rnf_renamer_test.sv
`timescale 1ns/1ps
module rnf_renamer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush;
  logic [1:0]  in_valid;
  logic [5:0]  in_op;
  logic [9:0]  in_dst, in_src1, in_src2;
  logic [63:0] in_imm;
  logic        in_ready;
  logic [1:0]  free_cnt;
  logic [11:0] free_tag;
  logic [1:0]  free_pop;
  logic [1:0]  out_valid;
  logic [5:0]  out_op;
  logic [11:0] out_pdst, out_psrc1, out_psrc2;
  logic [63:0] out_imm;
  logic [1:0]  out_folded;

  always #2.5 clk = ~clk;

  rnf_renamer uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_imm(in_imm),
    .in_ready(in_ready), .free_cnt(free_cnt), .free_tag(free_tag),
    .free_pop(free_pop), .out_valid(out_valid), .out_op(out_op),
    .out_pdst(out_pdst), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
    .out_imm(out_imm), .out_folded(out_folded)
  );

  typedef struct {
    logic [2:0]  op;
    logic [5:0]  pd, p1, p2;
    logic [31:0] imm;
    logic        fold;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   bad = 0;

  // Bench-side map model built from the requirements.
  logic [5:0]  mp [32];
  int          ms [32];
  logic [5:0]  mb [32];
  logic [31:0] mk [32];
  logic [5:0]  nt;

  function automatic logic [5:0] nxt(input logic [5:0] t);
    return (t == 6'd63) ? 6'd32 : t + 6'd1;
  endfunction

  function automatic logic [31:0] capv(input logic [32:0] x);
    return (x >= 33'd32) ? 32'd32 : x[31:0];
  endfunction

  task automatic model_home();
    for (int i = 0; i < 32; i++) begin
      mp[i] = 6'(i); ms[i] = 0; mb[i] = '0; mk[i] = '0;
    end
  endtask

  task automatic predict(input logic [2:0] op, input int d, input int s1, input int s2,
                         input logic [31:0] imm, input logic [5:0] tag, input string req);
    exp_t e;
    int cls;
    logic [31:0] knew;
    cls = (op == 3'd1) ? 1 : (op == 3'd2) ? 2 : (op == 3'd3) ? 3 : 0;
    e.op = op; e.pd = tag; e.p2 = mp[s2]; e.req = req;
    if (cls != 0 && ms[s1] == cls) begin
      e.p1 = mb[s1]; e.fold = 1'b1;
      if (cls == 1)      e.imm = mk[s1] + imm;
      else if (cls == 2) e.imm = mk[s1] | imm;
      else               e.imm = capv({1'b0, mk[s1]} + {1'b0, capv({1'b0, imm})});
      knew = e.imm;
    end else begin
      e.p1 = mp[s1]; e.fold = 1'b0; e.imm = imm;
      knew = (cls == 3) ? capv({1'b0, imm}) : imm;
    end
    if (op != 3'd0) begin
      mp[d] = tag; ms[d] = cls; mb[d] = e.p1; mk[d] = knew;
    end
    exp_q.push_back(e);
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Driver: called at a negedge, drives one group, returns at the next negedge.
  task automatic issue(input logic v0, input logic [2:0] o0, input int d0, input int a0,
                       input int b0, input logic [31:0] i0,
                       input logic v1, input logic [2:0] o1, input int d1, input int a1,
                       input int b1, input logic [31:0] i1, input string req);
    logic [5:0] t0, t1;
    int cnt;
    t0 = nt; t1 = nxt(nt); cnt = 0;
    in_valid = {v1, v0};
    in_op    = {o1, o0};
    in_dst   = {5'(d1), 5'(d0)};
    in_src1  = {5'(a1), 5'(a0)};
    in_src2  = {5'(b1), 5'(b0)};
    in_imm   = {i1, i0};
    free_tag = {t1, t0};
    free_cnt = 2'd2;
    if (v0) begin
      predict(o0, d0, a0, b0, i0, t0, req);
      if (o0 != 3'd0) cnt++;
    end
    if (v1) begin
      predict(o1, d1, a1, b1, i1, (cnt == 0) ? t0 : t1, req);
      if (o1 != 3'd0) cnt++;
    end
    #1;
    check(in_ready == 1'b1, req, "in_ready", 32'(in_ready), 32'd1);
    check(free_pop == 2'(cnt), "R2", "free_pop", 32'(free_pop), 32'(cnt));
    for (int i = 0; i < cnt; i++) nt = nxt(nt);
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic one(input logic [2:0] o, input int d, input int a, input int b,
                     input logic [31:0] i, input string req);
    issue(1'b1, o, d, a, b, i, 1'b0, 3'd0, 0, 0, 0, 32'd0, req);
  endtask

  // Monitor: pops the scoreboard whenever an output slot is valid.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (out_valid[k]) begin
          if (exp_q.size() == 0) begin
            checks++; bad++;
            $display("FAIL R10 unexpected output slot %0d: actual=1 expected=0", k);
          end else begin
            exp_t e;
            logic ok;
            e = exp_q.pop_front();
            ok = (out_op[k*3 +: 3] == e.op) && (out_psrc1[k*6 +: 6] == e.p1) &&
                 (out_psrc2[k*6 +: 6] == e.p2) && (out_imm[k*32 +: 32] == e.imm) &&
                 (out_folded[k] == e.fold) &&
                 ((e.op == 3'd0) || (out_pdst[k*6 +: 6] == e.pd));
            checks++;
            if (!ok) begin
              bad++;
              $display("FAIL %s slot %0d: actual op=%0d pd=%0d p1=%0d p2=%0d imm=%0h f=%0b expected op=%0d pd=%0d p1=%0d p2=%0d imm=%0h f=%0b",
                       e.req, k, out_op[k*3 +: 3], out_pdst[k*6 +: 6], out_psrc1[k*6 +: 6],
                       out_psrc2[k*6 +: 6], out_imm[k*32 +: 32], out_folded[k],
                       e.op, e.pd, e.p1, e.p2, e.imm, e.fold);
            end
          end
        end
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_valid = '0; in_op = '0; in_dst = '0;
    in_src1 = '0; in_src2 = '0; in_imm = '0; free_cnt = 2'd2; free_tag = '0;
    nt = 6'd32;
    model_home();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check(out_valid == 2'b00, "R1", "out_valid after reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 1);
    check(free_pop == 2'd0, "R1", "free_pop idle", 32'(free_pop), 0);

    // R1 identity map, R2 tag use: plain register-register op
    one(3'd6, 20, 3, 4, 32'd0, "R1");
    // R3/R4 chain of increments in consecutive groups
    one(3'd1, 2, 1, 0, 32'd1, "R3");
    one(3'd1, 1, 2, 0, 32'd1, "R3");
    one(3'd1, 2, 1, 0, 32'd1, "R4");
    // R8 producer and consumer in one group, then continued in next group
    issue(1'b1, 3'd1, 5, 6, 0, 32'd10, 1'b1, 3'd1, 7, 5, 0, 32'd5, "R8");
    one(3'd1, 8, 7, 0, 32'hFFFF_FFF0, "R4");
    // R3 wrap modulo 2^32
    one(3'd1, 14, 15, 0, 32'hFFFF_FFFF, "R3");
    one(3'd1, 16, 14, 0, 32'd2, "R3");
    // R5 OR folding
    one(3'd2, 4, 9, 0, 32'h0000_00F0, "R5");
    one(3'd2, 10, 4, 0, 32'h0000_0F0F, "R5");
    // R6 shift folding and cap
    one(3'd3, 11, 12, 0, 32'd3, "R6");
    one(3'd3, 13, 11, 0, 32'd4, "R6");
    one(3'd3, 17, 13, 0, 32'd30, "R6");
    one(3'd3, 18, 17, 0, 32'd1, "R6");
    one(3'd3, 19, 12, 0, 32'd100, "R6");
    // R7 right then left shift, left then right, mismatched add/or
    one(3'd4, 21, 11, 0, 32'd2, "R7");
    one(3'd3, 22, 21, 0, 32'd1, "R7");
    one(3'd2, 23, 2, 0, 32'd1, "R7");
    // R7 saturating add, load, ALU leave unknown notes
    one(3'd5, 24, 25, 0, 32'd1, "R7");
    one(3'd1, 26, 24, 0, 32'd1, "R7");
    one(3'd7, 27, 2, 0, 32'd8, "R7");
    one(3'd1, 28, 27, 0, 32'd1, "R7");
    one(3'd1, 29, 20, 0, 32'd1, "R7");
    // R2 no-op takes no tag; slot 1 gets the first free tag
    issue(1'b1, 3'd0, 0, 3, 4, 32'd0, 1'b1, 3'd1, 30, 2, 0, 32'd7, "R2");
    // R8 second slot source2 sees first slot's new mapping
    issue(1'b1, 3'd7, 31, 3, 0, 32'd0, 1'b1, 3'd6, 9, 2, 31, 32'd0, "R8");

    // R9 stall: one tag offered, two wanted; nothing taken, map unchanged
    in_valid = 2'b11; in_op = {3'd1, 3'd1}; in_dst = {5'd2, 5'd2};
    in_src1 = {5'd1, 5'd1}; in_src2 = '0; in_imm = {32'd9, 32'd9};
    free_cnt = 2'd1; free_tag = {nxt(nt), nt};
    #1;
    check(in_ready == 1'b0, "R9", "in_ready stalled", 32'(in_ready), 0);
    check(free_pop == 2'd0, "R9", "free_pop stalled", 32'(free_pop), 0);
    @(negedge clk);
    in_valid = '0; free_cnt = 2'd2;
    check(out_valid == 2'b00, "R9", "no output after stall", 32'(out_valid), 0);
    one(3'd1, 3, 2, 0, 32'd1, "R9");

    // R1 flush: map back home, in_ready low, no output next cycle
    in_valid = 2'b01; in_op = {3'd0, 3'd1}; in_dst = {5'd0, 5'd2};
    in_src1 = {5'd0, 5'd2}; flush = 1'b1;
    #1;
    check(in_ready == 1'b0, "R9", "in_ready during flush", 32'(in_ready), 0);
    @(negedge clk);
    flush = 1'b0; in_valid = '0;
    check(out_valid == 2'b00, "R1", "out_valid after flush", 32'(out_valid), 0);
    model_home();
    one(3'd1, 3, 2, 0, 32'd1, "R1");
    one(3'd1, 4, 3, 0, 32'd2, "R1");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", "scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule